// File: doc/BRIEF.md
# Byte-Bus Multiply and Divide Coprocessor

This block is an arithmetic helper on an 8-bit register bus. It computes an unsigned 8×8 product and an unsigned 16÷8 quotient with remainder. Software loads operands into latch registers and then writes the final operand, which starts the operation. Results are read back a byte at a time from result registers. The multiply and the divide share one 16-bit result pair. The divide also fills a separate 16-bit quotient pair.

A parameter picks how the arithmetic completes. In the single-cycle variant the result registers update on the same clock edge that accepts the starting write. In the iterative variant a shift-add loop (one step per multiplier bit) or a restoring shift-subtract loop (one step per dividend bit) runs while `busy` is high. A new start during that time discards the work in flight and begins again.

Register addresses on the 4-bit buses:
- 0: multiplier latch
- 1: multiplicand (starts the multiply)
- 2: dividend low byte
- 3: dividend high byte
- 4: divisor (starts the divide)
- 5: quotient low byte
- 6: quotient high byte
- 7: shared result low byte
- 8: shared result high byte

Top module: `muldiv_regs`

## Requirements
- R1: A write to address 0 only stores the multiplier. It changes neither result pair and does not raise `busy`.
- R2: A write to address 1 starts a multiply of the stored multiplier by the written byte. The 16-bit product goes to the shared pair: low byte at address 7, high byte at address 8.
- R3: Writes to addresses 2 and 3 store the dividend low and high bytes. They change no result and do not raise `busy`.
- R4: A nonzero write to address 4 starts a divide of the stored dividend by that byte. The quotient goes to addresses 5 (low) and 6 (high). The remainder goes to addresses 7 (low) and 8 (high).
- R5: A zero written to address 4 sets the quotient to 0xFFFF and the remainder to the stored dividend. In both variants this completes on the edge that accepts the write, with `busy` staying or going low.
- R6: Writes to addresses 5 through 8 are ignored. Both result pairs keep their contents.
- R7: With ITERATIVE=0, `busy` never rises. The result is readable in the cycle right after the starting write.
- R8: With ITERATIVE=1, `busy` is high for exactly 8 cycles after a multiply start and exactly 16 cycles after a nonzero divide start. The previous results stay readable during that time. The new results appear as `busy` falls.
- R9: A start written while `busy` is high restarts the full cycle count. It uses the operands stored at the moment of that restart.
- R10: After reset, every result byte reads 0 and `busy` is low. Reads of addresses other than 5 through 8 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 4 | Register address of the write |
| wrData | input | OPER_W | Write data byte |
| rdAddr | input | 4 | Register address of the read |
| rdData | output | OPER_W | Combinational read data |
| busy | output | 1 | Iterative operation in progress |

## Verification
The bench builds two copies with OPER_W=8 side by side: one with ITERATIVE=0 and one with ITERATIVE=1. Both copies take the same write stream, so every operand pattern is checked against both completion schemes. Only the iterative copy exposes the busy window, the held old results and the mid-operation restart. The single-cycle copy pins down next-cycle visibility. The divide-by-zero shortcut is checked on both copies, because only the iterative one has a loop that the shortcut bypasses.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MUL_OPA = 4'd0;
  localparam logic [ADDR_W-1:0] A_MUL_OPB = 4'd1;
  localparam logic [ADDR_W-1:0] A_DVD_LO  = 4'd2;
  localparam logic [ADDR_W-1:0] A_DVD_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DVSR    = 4'd4;
  localparam logic [ADDR_W-1:0] A_QUO_LO  = 4'd5;
  localparam logic [ADDR_W-1:0] A_QUO_HI  = 4'd6;
  localparam logic [ADDR_W-1:0] A_RES_LO  = 4'd7;
  localparam logic [ADDR_W-1:0] A_RES_HI  = 4'd8;

  typedef enum logic {OP_MUL = 1'b0, OP_DIV = 1'b1} opKind_e;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic ldOpA;
    logic ldDvdLo;
    logic ldDvdHi;
    logic startMul;
    logic startDiv;
    logic zeroDiv;
    logic stepMul;
    logic stepDiv;
    logic lastStep;
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int OPER_W    = 8,
  parameter bit ITERATIVE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrDataZero,
  output mdStrobe_t         st,
  output logic              busy
);

  localparam int MUL_STEPS = OPER_W;
  localparam int DIV_STEPS = 2 * OPER_W;
  localparam int CNT_W     = $clog2(DIV_STEPS + 1);

  localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(MUL_STEPS - 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_STEPS - 1);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  opKind_e          opQ;
  logic             anyStart;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = (opQ == OP_MUL) ? MUL_LAST : DIV_LAST;

  always_comb begin
    st          = '0;
    st.ldOpA    = wrEn && (wrAddr == A_MUL_OPA);
    st.ldDvdLo  = wrEn && (wrAddr == A_DVD_LO);
    st.ldDvdHi  = wrEn && (wrAddr == A_DVD_HI);
    st.startMul = wrEn && (wrAddr == A_MUL_OPB);
    st.startDiv = wrEn && (wrAddr == A_DVSR) && !wrDataZero;
    st.zeroDiv  = wrEn && (wrAddr == A_DVSR) && wrDataZero;
    anyStart    = st.startMul || st.startDiv || st.zeroDiv;
    if (ITERATIVE && busyQ && !anyStart) begin
      st.stepMul  = (opQ == OP_MUL);
      st.stepDiv  = (opQ == OP_DIV);
      st.lastStep = (cntQ == lastCnt);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
      opQ   <= OP_MUL;
    end else if (ITERATIVE && (st.startMul || st.startDiv)) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
      opQ   <= st.startDiv ? OP_DIV : OP_MUL;
    end else if (st.zeroDiv) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (st.stepMul || st.stepDiv) begin
      cntQ <= cntQ + 1'b1;
      if (st.lastStep) busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int OPER_W    = 8,
  parameter bit ITERATIVE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mdStrobe_t             st,
  input  logic [OPER_W-1:0]     wrData,
  output logic [2*OPER_W-1:0]   quoVal,
  output logic [2*OPER_W-1:0]   resVal,
  output logic [OPER_W-1:0]     opAVal,
  output logic [2*OPER_W-1:0]   dvdVal
);

  localparam int W2 = 2 * OPER_W;

  logic [OPER_W-1:0] opAQ;
  logic [W2-1:0]     dvdQ;

  // One shift-add step: {acc, mcand, mplier}
  function automatic logic [W2+W2+OPER_W-1:0] mulStep(
    input logic [W2-1:0] acc, input logic [W2-1:0] mcand,
    input logic [OPER_W-1:0] mplier);
    logic [W2-1:0] accN;
    accN = mplier[0] ? acc + mcand : acc;
    return {accN, mcand << 1, mplier >> 1};
  endfunction

  // One restoring step: {rem, quo}; quo shifts dividend out and quotient in
  function automatic logic [OPER_W+W2-1:0] divStep(
    input logic [OPER_W-1:0] rem, input logic [W2-1:0] quo,
    input logic [OPER_W-1:0] dvsr);
    logic [OPER_W:0]   trial;
    logic [OPER_W-1:0] remN;
    logic              qBit;
    trial = {rem, quo[W2-1]};
    if (trial >= {1'b0, dvsr}) begin
      trial = trial - {1'b0, dvsr};
      qBit  = 1'b1;
    end else begin
      qBit  = 1'b0;
    end
    remN = trial[OPER_W-1:0];
    return {remN, quo[W2-2:0], qBit};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAQ <= '0;
      dvdQ <= '0;
    end else begin
      if (st.ldOpA)   opAQ              <= wrData;
      if (st.ldDvdLo) dvdQ[OPER_W-1:0]  <= wrData;
      if (st.ldDvdHi) dvdQ[W2-1:OPER_W] <= wrData;
    end
  end

  logic          commitMul;
  logic          commitDiv;
  logic [W2-1:0] mulValue;
  logic [W2-1:0] quoValue;
  logic [W2-1:0] remValue;

  generate
    if (ITERATIVE) begin : g_iter
      logic [W2-1:0]     accQ, mcandQ, quoWQ;
      logic [OPER_W-1:0] mplierQ, remQ, dvsrQ;
      logic [W2-1:0]     accN, mcandN, quoWN;
      logic [OPER_W-1:0] mplierN, remN;

      always_comb begin
        {accN, mcandN, mplierN} = mulStep(accQ, mcandQ, mplierQ);
        {remN, quoWN}           = divStep(remQ, quoWQ, dvsrQ);
        commitMul = st.stepMul && st.lastStep;
        commitDiv = st.stepDiv && st.lastStep;
        mulValue  = accN;
        quoValue  = quoWN;
        remValue  = {{OPER_W{1'b0}}, remN};
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          accQ    <= '0;
          mcandQ  <= '0;
          mplierQ <= '0;
          remQ    <= '0;
          quoWQ   <= '0;
          dvsrQ   <= '0;
        end else if (st.startMul) begin
          accQ    <= '0;
          mcandQ  <= {{OPER_W{1'b0}}, opAQ};
          mplierQ <= wrData;
        end else if (st.startDiv) begin
          remQ    <= '0;
          quoWQ   <= dvdQ;
          dvsrQ   <= wrData;
        end else if (st.stepMul) begin
          accQ    <= accN;
          mcandQ  <= mcandN;
          mplierQ <= mplierN;
        end else if (st.stepDiv) begin
          remQ    <= remN;
          quoWQ   <= quoWN;
        end
      end
    end else begin : g_single
      logic unusedSteps;
      assign unusedSteps = st.stepMul ^ st.stepDiv ^ st.lastStep;

      always_comb begin
        logic [W2-1:0]     acc, mcand, quo;
        logic [OPER_W-1:0] mplier, rem;
        acc    = '0;
        mcand  = {{OPER_W{1'b0}}, opAQ};
        mplier = wrData;
        for (int i = 0; i < OPER_W; i++) begin
          {acc, mcand, mplier} = mulStep(acc, mcand, mplier);
        end
        rem = '0;
        quo = dvdQ;
        for (int i = 0; i < W2; i++) begin
          {rem, quo} = divStep(rem, quo, wrData);
        end
        commitMul = st.startMul;
        commitDiv = st.startDiv;
        mulValue  = acc;
        quoValue  = quo;
        remValue  = {{OPER_W{1'b0}}, rem};
      end
    end
  endgenerate

  logic [W2-1:0] quoQ, resQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoQ <= '0;
      resQ <= '0;
    end else if (st.zeroDiv) begin
      quoQ <= '1;
      resQ <= dvdQ;
    end else if (commitMul) begin
      resQ <= mulValue;
    end else if (commitDiv) begin
      quoQ <= quoValue;
      resQ <= remValue;
    end
  end

  assign quoVal = quoQ;
  assign resVal = resQ;
  assign opAVal = opAQ;
  assign dvdVal = dvdQ;

endmodule

// File: rtl/muldiv_regs.sv
module muldiv_regs
  import muldiv_pkg::*;
#(
  parameter int OPER_W    = 8,
  parameter bit ITERATIVE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [OPER_W-1:0] wrData,
  input  logic [3:0]        rdAddr,
  output logic [OPER_W-1:0] rdData,
  output logic              busy
);

  localparam int W2 = 2 * OPER_W;

  mdStrobe_t     st;
  logic [W2-1:0] quoVal, resVal, dvdVal;
  logic [OPER_W-1:0] opAVal;

  muldiv_ctrl #(.OPER_W(OPER_W), .ITERATIVE(ITERATIVE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrDataZero (wrData == '0),
    .st         (st),
    .busy       (busy)
  );

  muldiv_datapath #(.OPER_W(OPER_W), .ITERATIVE(ITERATIVE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .wrData (wrData),
    .quoVal (quoVal),
    .resVal (resVal),
    .opAVal (opAVal),
    .dvdVal (dvdVal)
  );

  always_comb begin
    case (rdAddr)
      A_QUO_LO: rdData = quoVal[OPER_W-1:0];
      A_QUO_HI: rdData = quoVal[W2-1:OPER_W];
      A_RES_LO: rdData = resVal[OPER_W-1:0];
      A_RES_HI: rdData = resVal[W2-1:OPER_W];
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/muldiv_regs_chk.sv
module muldiv_regs_chk #(
  parameter int OPER_W    = 8,
  parameter bit ITERATIVE = 1'b1
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [3:0]          wrAddr,
  input logic [OPER_W-1:0]   wrData,
  input logic                busy,
  input logic [2*OPER_W-1:0] quoVal,
  input logic [2*OPER_W-1:0] resVal,
  input logic [OPER_W-1:0]   opAVal,
  input logic [2*OPER_W-1:0] dvdVal
);

  localparam int W2 = 2 * OPER_W;
  localparam int W4 = 4 * OPER_W;

  logic startWr;
  assign startWr = wrEn && (wrAddr == 4'd1 || wrAddr == 4'd4);

  // R5
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 4'd4 && wrData == '0) |=>
      (quoVal == '1 && resVal == $past(dvdVal) && !busy));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startWr) |=> ($stable(resVal) && $stable(quoVal)));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn && (wrAddr == 4'd1 ||
                                   (wrAddr == 4'd4 && wrData != '0))));

  // R2
  single_mul_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ITERATIVE && wrEn && wrAddr == 4'd1) |=>
      (resVal == W2'($past(opAVal)) * W2'($past(wrData))));

  // R4
  single_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ITERATIVE && wrEn && wrAddr == 4'd4 && wrData != '0) |=>
      ((W4'(quoVal) * W4'($past(wrData)) + W4'(resVal) == W4'($past(dvdVal)))
       && (resVal < W2'($past(wrData)))));

endmodule

bind muldiv_regs muldiv_regs_chk #(.OPER_W(OPER_W), .ITERATIVE(ITERATIVE)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .busy   (busy),
  .quoVal (quoVal),
  .resVal (resVal),
  .opAVal (opAVal),
  .dvdVal (dvdVal)
);

// File: tb/muldiv_regs_bench.sv
module muldiv_regs_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdS, rdI;
  logic       busyS, busyI;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  muldiv_regs #(.OPER_W(8), .ITERATIVE(1'b0)) u_muldiv_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdS), .busy(busyS));

  muldiv_regs #(.OPER_W(8), .ITERATIVE(1'b1)) u_muldiv_regs_iter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdI), .busy(busyI));

  function automatic logic [15:0] expQuo(input logic [15:0] a, input logic [7:0] d);
    return (d == 0) ? 16'hFFFF : a / {8'd0, d};
  endfunction

  function automatic logic [15:0] expRem(input logic [15:0] a, input logic [7:0] d);
    return (d == 0) ? a : a % {8'd0, d};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdPair(input logic [3:0] lo, output logic [15:0] s, output logic [15:0] i);
    rdAddr = lo;       #1; s[7:0]  = rdS; i[7:0]  = rdI;
    rdAddr = lo + 1'b1; #1; s[15:8] = rdS; i[15:8] = rdI;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busyI && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic doMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] s, i;
    int n;
    wr(4'd0, a);
    wr(4'd1, b);
    rdPair(4'd7, s, i);
    chk("R7", "single product next cycle", s, a * b);
    chk("R7", "single busy low", busyS, 0);
    waitIdle(n);
    chk("R8", "multiply busy cycles", n, 8);
    rdPair(4'd7, s, i);
    chk("R2", "iterative product", i, a * b);
  endtask

  task automatic doDiv(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] s, i, qs, qi;
    int n;
    wr(4'd2, a[7:0]);
    wr(4'd3, a[15:8]);
    wr(4'd4, d);
    rdPair(4'd5, qs, qi);
    rdPair(4'd7, s, i);
    chk("R4", "single quotient", qs, expQuo(a, d));
    chk("R4", "single remainder", s, expRem(a, d));
    waitIdle(n);
    chk("R8", "divide busy cycles", n, (d == 0) ? 0 : 16);
    rdPair(4'd5, qs, qi);
    rdPair(4'd7, s, i);
    chk("R4", "iterative quotient", qi, expQuo(a, d));
    chk("R4", "iterative remainder", i, expRem(a, d));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, i, qs, qi;
    int n;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    rdPair(4'd5, qs, qi);
    rdPair(4'd7, s, i);
    chk("R10", "reset quotient", {qs, qi}, 0);
    chk("R10", "reset result", {s, i}, 0);
    chk("R10", "reset busy", {busyS, busyI}, 0);

    // directed products
    doMul(8'hFF, 8'hFF);
    doMul(8'h00, 8'h7B);
    doMul(8'h01, 8'h80);

    // R1: multiplier latch write alone
    wr(4'd0, 8'h99);
    rdPair(4'd7, s, i);
    chk("R1", "result after latch write", {s, i}, {16'h0080, 16'h0080});
    chk("R1", "busy after latch write", busyI, 0);

    // R10: non-result addresses read zero
    rdAddr = 4'd0; #1; chk("R10", "read addr 0", {rdS, rdI}, 0);
    rdAddr = 4'd9; #1; chk("R10", "read addr 9", {rdS, rdI}, 0);

    // directed divides
    doDiv(16'hFFFF, 8'h01);
    doDiv(16'hFFFF, 8'hFF);
    doDiv(16'h0005, 8'h07);
    doDiv(16'hABCD, 8'h10);

    // R3: dividend writes alone
    wr(4'd2, 8'h11);
    wr(4'd3, 8'h22);
    rdPair(4'd5, qs, qi);
    rdPair(4'd7, s, i);
    chk("R3", "quotient after dividend writes", {qs, qi}, {16'h0ABC, 16'h0ABC});
    chk("R3", "result after dividend writes", {s, i}, {16'h000D, 16'h000D});
    chk("R3", "busy after dividend writes", busyI, 0);

    // R6: writes to result addresses ignored
    for (int a = 5; a <= 8; a++) wr(4'(a), 8'hA5);
    rdPair(4'd5, qs, qi);
    rdPair(4'd7, s, i);
    chk("R6", "quotient after result writes", {qs, qi}, {16'h0ABC, 16'h0ABC});
    chk("R6", "result after result writes", {s, i}, {16'h000D, 16'h000D});

    // R5: zero divisor, completes at once
    wr(4'd2, 8'h34);
    wr(4'd3, 8'h12);
    wr(4'd4, 8'h00);
    chk("R5", "busy on zero divide", busyI, 0);
    rdPair(4'd5, qs, qi);
    rdPair(4'd7, s, i);
    chk("R5", "zero divide quotient", {qs, qi}, {16'hFFFF, 16'hFFFF});
    chk("R5", "zero divide remainder", {s, i}, {16'h1234, 16'h1234});

    // R8: old results held while busy
    doMul(8'd3, 8'd5);
    wr(4'd0, 8'd2);
    wr(4'd1, 8'd7);
    chk("R8", "busy after start", busyI, 1);
    rdPair(4'd7, s, i);
    chk("R8", "old result held while busy", i, 16'd15);
    chk("R7", "single new result", s, 16'd14);
    waitIdle(n);
    rdPair(4'd7, s, i);
    chk("R8", "new result after busy", i, 16'd14);

    // R9: restart in flight with fresh operands
    wr(4'd0, 8'd10);
    wr(4'd1, 8'd10);
    repeat (2) @(negedge clk);
    wr(4'd0, 8'd20);
    wr(4'd1, 8'd3);
    waitIdle(n);
    chk("R9", "busy cycles after restart", n, 8);
    rdPair(4'd7, s, i);
    chk("R9", "restarted product", {s, i}, {16'd60, 16'd60});

    // R9: divide restarted by multiply
    wr(4'd2, 8'hFF);
    wr(4'd3, 8'h00);
    wr(4'd4, 8'd3);
    repeat (4) @(negedge clk);
    wr(4'd0, 8'd9);
    wr(4'd1, 8'd9);
    waitIdle(n);
    rdPair(4'd7, s, i);
    chk("R9", "multiply replaced divide", i, 16'd81);

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(1, 0) == 0) doMul(8'($urandom), 8'($urandom));
      else doDiv(16'($urandom), ($urandom_range(9, 0) == 0) ? 8'd0 : 8'($urandom));
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule